// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers single-cycle event pulses from a set of hardware sources into a status register, one bit per source. For example, one bit can stand for a finished receive and another for a finished management frame. Software clears status bits by writing ones to them. A per-bit enable register decides which sources may report. Toward the host the block drives a registered, one-cycle interrupt request pulse, which a message-signaled interrupt path turns into a message.

A request is sent only when the status register goes from all-zero to non-zero. If another bit is already set, a new event is still recorded but produces no pulse. An event on a source whose enable bit is clear does not touch the status register. It is parked in a hidden pending store instead. When software later sets that enable bit, the parked event moves into the status register and a fresh pulse is sent, even if other status bits are set.

This behaviour creates a known race. If software reads the status, an event arrives, and software then clears only the bits it read, the new bit stays set and no further pulse follows. The safe handler sequence avoids this:

1. Disable reporting.
2. Read the status register.
3. Clear the bits that were read.
4. Re-enable reporting.

The pulse generator is a two-state machine:

- **ST_QUIET**: the status register is all-zero.
- **ST_FLAGGED**: at least one status bit is set.

Its transitions are:

- **QUIET to FLAGGED** (*arm*): the next status value is non-zero. This fires a pulse.
- **FLAGGED to QUIET** (*drain*): the next status value is zero.
- **FLAGGED to FLAGGED** (*hold*): the status stays non-zero. This fires a pulse only on a release of parked events.
- **QUIET to QUIET** (*idle*): the status stays zero.

Top module: `irq_status_agg`

## Requirements
- R1: After synchronous active-low reset, the status register, the enable register and the pending store are all zero, and `irq` is low.
- R2: An event pulse on a source whose enable bit is set sets that status bit at the next clock edge. When the status was all-zero before that edge, `irq` is high in the cycle right after the edge.
- R3: A write to address 0 clears every status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R4: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: An event that lands while any status bit is already set is recorded, but `irq` stays low.
- R6: An event on a source whose enable bit is clear leaves the status register unchanged and raises no `irq`. The event is held in the pending store, which no register read shows.
- R7: One cycle after an enable bit is set while that source has a parked event, the event appears in the status register and `irq` pulses, even if other status bits are set. A parked bit whose enable stays clear remains parked.
- R8: In the race, a bit set between the status read and the clear of the read bits stays set. No `irq` follows, either for that bit or for later events.
- R9: The sequence disable, read, clear, re-enable still produces an `irq` for an event that arrives after the read.
- R10: A write to address 1 loads the enable register. Reads return the status at address 0, the enable register at address 1, and zero at any other address. Writes to any other address have no effect.
- R11: `irq` is a one-cycle pulse. After a single event from an all-zero status it is low in the second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt | input | NUM_SRC | Single-cycle event pulse per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 status, 1 enable) |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr (combinational) |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions take the event inputs to be single-cycle pulses sampled at a clock edge. They also take `reg_wr` to be a one-cycle strobe whose address and data are stable around the edge that samples it. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. It restarts each scenario from reset, so the pending store and the enable state are known at the start of every check.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_FLAGGED = 1'b1
    } fire_state_e;

    localparam int unsigned ADDR_STATUS = 0;
    localparam int unsigned ADDR_ENABLE = 1;
endpackage

// File: rtl/irq_src_slice.sv
module irq_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic en,
    input  logic clr,
    output logic status_q,
    output logic status_d,
    output logic pend_q,
    output logic rel
);
    logic pend_d;

    always_comb begin
        rel      = pend_q & en;
        status_d = (ev & en) | rel | (status_q & ~clr);
        if (rel) pend_d = 1'b0;
        else     pend_d = pend_q | (ev & ~en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            status_q <= status_d;
            pend_q   <= pend_d;
        end
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && en) |=> status_q);
    assert_masked_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !en && !clr) |=> (pend_q && status_q == $past(status_q)));
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && en) |=> (status_q && !pend_q));
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev && !(pend_q && en)) |=> !status_q);
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    input  logic [NUM_SRC-1:0] status_vec,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE);

    logic hit_stat, hit_en;

    always_comb begin
        hit_stat = reg_wr && (reg_addr == A_STAT);
        hit_en   = reg_wr && (reg_addr == A_EN);
        clr_mask = hit_stat ? reg_wdata : '0;
        if (reg_addr == A_STAT)    reg_rdata = status_vec;
        else if (reg_addr == A_EN) reg_rdata = en_q;
        else                       reg_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (hit_en) en_q <= reg_wdata;
    end

    assert_en_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EN) |=> (en_q == $past(reg_wdata)));
    assert_en_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_EN) |=> $stable(en_q));
endmodule

// File: rtl/irq_fire_fsm.sv
module irq_fire_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic now_any,
    input  logic next_any,
    input  logic rel_any,
    output logic irq
);
    fire_state_e state_q, state_d;
    logic        fire;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_QUIET: begin
                if (next_any) begin
                    state_d = ST_FLAGGED;
                    fire    = 1'b1;
                end
            end
            ST_FLAGGED: begin
                if (!next_any) state_d = ST_QUIET;
                fire = rel_any;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end

    assert_state_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_QUIET) == !now_any));
    assert_irq_has_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> now_any);
    assert_arm_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!now_any && next_any) |=> irq);
    assert_no_refire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (now_any && !rel_any) |=> !irq);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq
);
    logic [NUM_SRC-1:0] status_q, status_d, pend_q, rel, en_q, clr_mask;

    irq_reg_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_vec(status_q),
        .en_q      (en_q),
        .clr_mask  (clr_mask),
        .reg_rdata (reg_rdata)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (evt[i]),
            .en      (en_q[i]),
            .clr     (clr_mask[i]),
            .status_q(status_q[i]),
            .status_d(status_d[i]),
            .pend_q  (pend_q[i]),
            .rel     (rel[i])
        );
    end

    irq_fire_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .now_any (|status_q),
        .next_any(|status_d),
        .rel_any (|rel),
        .irq     (irq)
    );

    assert_pend_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & $past(en_q) & en_q) == '0));
endmodule

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;
    localparam int N = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          irq;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;

    irq_status_agg #(.NUM_SRC(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; evt = '0; reg_wr = 1'b0;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        irq_cnt = 0;
    endtask

    task automatic do_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = N'(d);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic do_read(input int a, output int d);
        reg_addr = AW'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic pulse(input int m);
        @(negedge clk);
        evt = N'(m);
        @(negedge clk);
        evt = '0;
        #1;
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        do_read(0, v); chk("R1 status", v, 0);
        do_read(1, v); chk("R1 enable", v, 0);
        chk("R1 irq", int'(irq), 0);
        do_write(1, 'hFF);
        idle(2);
        do_read(0, v); chk("R1 pending empty", v, 0);
        chk("R1 irq count", irq_cnt, 0);
    endtask

    task automatic t_basic();
        int v;
        do_reset();
        do_write(1, 'hFF);
        pulse('h01);
        chk("R2 irq on first event", int'(irq), 1);
        do_read(0, v); chk("R2 status", v, 'h01);
        idle(1);
        chk("R11 irq one cycle", int'(irq), 0);
        pulse('h02);
        chk("R5 no irq when set", int'(irq), 0);
        do_read(0, v); chk("R5 status recorded", v, 'h03);
        do_write(0, 'h00);
        do_read(0, v); chk("R3 zero write keeps", v, 'h03);
        do_write(0, 'h01);
        do_read(0, v); chk("R3 clear one bit", v, 'h02);
        do_write(0, 'h02);
        do_read(0, v); chk("R3 clear to zero", v, 0);
        pulse('h80);
        chk("R2 irq after drain", int'(irq), 1);
        idle(2);
        chk("R2 irq count", irq_cnt, 2);
    endtask

    task automatic t_collide();
        int v;
        do_reset();
        do_write(1, 'hFF);
        pulse('h08);
        @(negedge clk);
        evt = N'('h08); reg_wr = 1'b1; reg_addr = 0; reg_wdata = N'('h08);
        @(negedge clk);
        evt = '0; reg_wr = 1'b0;
        #1;
        do_read(0, v); chk("R4 set beats clear", v, 'h08);
    endtask

    task automatic t_regs();
        int v;
        do_reset();
        do_write(1, 'h5A);
        do_read(1, v); chk("R10 enable readback", v, 'h5A);
        do_write(2, 'hFF);
        do_read(1, v); chk("R10 other addr no effect", v, 'h5A);
        do_read(2, v); chk("R10 other addr reads zero", v, 0);
    endtask

    task automatic t_masked();
        int v;
        do_reset();
        do_write(1, 'h01);
        pulse('h01);
        chk("R2 irq", int'(irq), 1);
        idle(1);
        pulse('h30);
        chk("R6 no irq masked", int'(irq), 0);
        do_read(0, v); chk("R6 status unchanged", v, 'h01);
        do_write(1, 'h11);
        do_read(0, v); chk("R7 not yet moved", v, 'h01);
        idle(1);
        chk("R7 irq on release", int'(irq), 1);
        do_read(0, v); chk("R7 only enabled bit moves", v, 'h11);
        do_write(1, 'h31);
        idle(1);
        chk("R7 second release irq", int'(irq), 1);
        do_read(0, v); chk("R7 second release status", v, 'h31);
        idle(2);
        chk("R7 irq count", irq_cnt, 3);
    endtask

    task automatic t_race();
        int v, seen;
        do_reset();
        do_write(1, 'hFF);
        pulse('h01);
        idle(1);
        do_read(0, seen);
        pulse('h02);
        do_write(0, seen);
        do_read(0, v); chk("R8 late bit left set", v, 'h02);
        pulse('h04);
        idle(3);
        chk("R8 no further irq", irq_cnt, 1);
        do_read(0, v); chk("R8 status stuck", v, 'h06);
    endtask

    task automatic t_safe();
        int v, seen;
        do_reset();
        do_write(1, 'hFF);
        pulse('h01);
        idle(1);
        do_write(1, 'h00);
        do_read(0, seen);
        pulse('h02);
        do_read(0, v); chk("R6 held while disabled", v, 'h01);
        do_write(0, seen);
        do_read(0, v); chk("R9 cleared to zero", v, 0);
        do_write(1, 'hFF);
        idle(1);
        chk("R9 irq after re-enable", int'(irq), 1);
        do_read(0, v); chk("R9 held event visible", v, 'h02);
        idle(2);
        chk("R9 irq count", irq_cnt, 2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_collide();
        t_regs();
        t_masked();
        t_race();
        t_safe();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule